// File: doc/BRIEF.md
# Spectral Bit Histogram Accumulator

This block collects statistics over a burst of binary spectrum vectors. Each incoming vector carries one flag per frequency bin. On every cycle the write strobe is high, the block adds each flag to its own per-bin counter. Over one spoken word this builds a histogram of how often each bin was active.

When a send request arrives, the block stops accumulating. It streams the counters out, four per 32-bit word, through a FIFO-style master port that obeys a full flag. It marks the final word with a control bit. After the final word is accepted, it pulses a completion strobe and clears every counter, ready for the next word. Accumulation and transmission never overlap: there is one bank of counters and no second buffer.

Top module: `spectral_hist`

## Requirements
- R1: While idle, every cycle with `bin_wr` high adds `bin_vec[i]` (0 or 1) to counter i, for all 128 bins independently.
- R2: Each counter is 8 bits and saturates at 255; further set bits leave it at 255.
- R3: A cycle with `send_req` high while idle starts a transfer of 32 words. Word k carries counter 4k+j in bits [8j+7:8j], j = 0..3, and words leave in order k = 0..31.
- R4: No word is written (`m_wr` low) while `m_full` is high. A word held back by `m_full` is offered again unchanged, so no word is lost or repeated.
- R5: `m_ctrl` is high on the 32nd word of a transfer and low on words 0..30.
- R6: `send_done` is high for exactly one cycle, the cycle after the last word is written, and all counters read zero from that cycle on.
- R7: While a transfer is in progress, `bin_wr` and `send_req` have no effect: the words sent and the following histogram are unchanged.
- R8: After reset, all counters are zero, `m_wr` is low and `send_done` is low.
- R9: A vector written in the same cycle as a send request is counted and appears in that transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bin_vec | input | 128 | Binary spectrum vector, one flag per bin |
| bin_wr | input | 1 | Vector valid strobe |
| send_req | input | 1 | Request to transmit the histogram |
| send_done | output | 1 | One-cycle pulse when a transfer has finished |
| m_data | output | 32 | Stream word, four packed 8-bit counters |
| m_ctrl | output | 1 | Marks the last word of a transfer |
| m_wr | output | 1 | Stream write strobe |
| m_full | input | 1 | Stream sink cannot accept a word this cycle |

## Verification
The assertions assume that the sink treats `m_wr` in a cycle with `m_full` low as an accepted word. They also assume that reset is held over the first clock edges, so no past-value check reaches before it. The bench drives `m_full` only between edges, in fixed patterns (never full, alternating, mostly full, and a long initial stall), so every transfer completes. While transfers are in flight it also drives `bin_wr` and `send_req` high on purpose. It releases both before the completion cycle, so an idle request never restarts a transfer that was not intended.

// File: rtl/spectral_hist.sv
module spectral_hist #(
  parameter int NBINS = 128,
  parameter int CW    = 8,
  parameter int WW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBINS-1:0] bin_vec,
  input  logic             bin_wr,
  input  logic             send_req,
  output logic             send_done,
  output logic [WW-1:0]    m_data,
  output logic             m_ctrl,
  output logic             m_wr,
  input  logic             m_full
);
  localparam int PER = WW / CW;
  localparam int NW  = NBINS / PER;
  localparam int IW  = (NW > 1) ? $clog2(NW) : 1;
  localparam int BW  = (NBINS > 1) ? $clog2(NBINS) : 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic          busy;
  logic [IW-1:0] widx;
  logic          done_q;
  logic [CW-1:0] cnt [NBINS];

  wire accept = busy & ~m_full;
  wire last   = (widx == IW'(NW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      widx <= '0;
    end else if (!busy) begin
      if (send_req) begin
        busy <= 1'b1;
        widx <= '0;
      end
    end else if (accept) begin
      widx <= widx + IW'(1);
      if (last) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= accept & last;
  end

  for (genvar b = 0; b < NBINS; b++) begin : g_bin
    always_ff @(posedge clk) begin
      if (rst || (accept && last))
        cnt[b] <= '0;
      else if (!busy && bin_wr && bin_vec[b] && cnt[b] != CMAX)
        cnt[b] <= cnt[b] + CW'(1);
    end
  end

  for (genvar j = 0; j < PER; j++) begin : g_pack
    wire [BW-1:0] sel = BW'(widx) * BW'(PER) + BW'(j);
    assign m_data[j*CW +: CW] = cnt[sel];
  end

  assign m_wr      = accept;
  assign m_ctrl    = busy & last;
  assign send_done = done_q;

  a_r4_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
    m_full |-> !m_wr);

  a_r4_word_held: assert property (@(posedge clk) disable iff (rst)
    (busy && m_full) |=> (busy && $stable(m_data)));

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (rst)
    (m_wr && m_ctrl) |=> send_done);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    send_done |=> !send_done);

  a_r6_cleared: assert property (@(posedge clk) disable iff (rst)
    send_done |-> (cnt[0] == '0 && cnt[NBINS-1] == '0));

  a_r2_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !send_done |-> (cnt[0] >= $past(cnt[0])));

  a_r7_hold_in_send: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(cnt[0]) && $stable(cnt[NBINS-1])));
endmodule

// File: tb/spectral_hist_tb.sv
module spectral_hist_tb;
  localparam int NB = 128, CW = 8, WW = 32, PER = 4, NW = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic [NB-1:0] bin_vec = '0;
  logic bin_wr = 1'b0, send_req = 1'b0, m_full = 1'b0;
  logic send_done, m_ctrl, m_wr;
  logic [WW-1:0] m_data;

  int checks = 0, fails = 0;
  int exp_c [NB];
  bit finished = 0;

  always #2 clk = ~clk;

  spectral_hist #(.NBINS(NB), .CW(CW), .WW(WW)) u_dut (
    .clk(clk), .rst(rst), .bin_vec(bin_vec), .bin_wr(bin_wr),
    .send_req(send_req), .send_done(send_done), .m_data(m_data),
    .m_ctrl(m_ctrl), .m_wr(m_wr), .m_full(m_full));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [NB-1:0] vec_gen(input int n);
    logic [NB-1:0] v;
    for (int i = 0; i < NB; i++) v[i] = (((i * (n + 1) + n) % 7) < 3);
    return v;
  endfunction

  function automatic logic [31:0] exp_word(input int k);
    logic [31:0] w;
    for (int j = 0; j < PER; j++) w[j*CW +: CW] = exp_c[PER*k + j][CW-1:0];
    return w;
  endfunction

  function automatic bit full_pat(input int mode, input int cyc);
    case (mode)
      1: return (cyc % 2) == 0;
      2: return (cyc % 3) != 2;
      3: return cyc < 5;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_add(input logic [NB-1:0] v);
    for (int i = 0; i < NB; i++) if (v[i] && exp_c[i] < 255) exp_c[i]++;
  endtask

  task automatic write_vec(input logic [NB-1:0] v);
    @(negedge clk);
    bin_vec = v; bin_wr = 1'b1;
    model_add(v);
  endtask

  task automatic do_send(input int mode, input bit noise, input bit coinc, input logic [NB-1:0] cv);
    int k = 0, cyc = 0;
    @(negedge clk);
    bin_wr = coinc; bin_vec = cv; send_req = 1'b1;
    if (coinc) model_add(cv);
    @(negedge clk);
    send_req = 1'b0; bin_wr = 1'b0;
    while (k < NW && cyc < 400) begin
      m_full = full_pat(mode, cyc);
      if (noise) begin bin_wr = 1'b1; bin_vec = '1; send_req = 1'b1; end
      #1;
      if (m_full) chk(!m_wr, "R4 write while full", m_wr, 0);
      else begin
        chk(m_wr, "R4 word offered", m_wr, 1);
        chk(m_data == exp_word(k), $sformatf("R3 word %0d", k), m_data, exp_word(k));
        chk(m_ctrl == (k == NW - 1), "R5 ctrl", m_ctrl, (k == NW - 1));
        k++;
      end
      cyc++;
      @(negedge clk);
      bin_wr = 1'b0; send_req = 1'b0; m_full = 1'b0;
    end
    #1;
    chk(send_done, "R6 done pulse", send_done, 1);
    chk(!m_wr, "R6 idle after send", m_wr, 0);
    for (int i = 0; i < NB; i++) exp_c[i] = 0;
    @(negedge clk); #1;
    chk(!send_done, "R6 one cycle", send_done, 0);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) exp_c[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!send_done, "R8 done low", send_done, 0);
    chk(!m_wr, "R8 no write", m_wr, 0);
    do_send(0, 0, 0, '0);                       // R8 zero counters
    for (int n = 0; n < 20; n++) write_vec(vec_gen(n));   // R1
    do_send(0, 0, 0, '0);
    do_send(1, 0, 0, '0);                       // R6 counters cleared
    for (int n = 0; n < 300; n++) write_vec({64{2'b01}}); // R2 saturation
    for (int n = 0; n < 3; n++) write_vec(vec_gen(n));
    do_send(1, 1, 0, '0);                       // R7 noise ignored
    for (int mode = 0; mode < 4; mode++) begin
      for (int n = 0; n < 5 + mode * 37; n++) write_vec(vec_gen(n + mode));
      do_send(mode, mode[0], mode >= 2, vec_gen(99)); // R9 coincident write
    end
    for (int n = 0; n < 260; n++) write_vec('1);
    do_send(3, 1, 1, '1);                       // R2 R9 saturated with coincident write
    do_send(2, 0, 0, '0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule